// File: doc/BRIEF.md
# Gatable Astable and One-Shot Pulse Timer

This block is a clocked, fully digital combination of a free-running square-wave oscillator and a one-shot pulse generator. Three programmable tick counts replace the analog timing network: an initial high segment, a regular high segment and a low segment. A phase counter runs the oscillator through one high segment and then one low segment. A divide-by-two stage flips the main output at the end of each oscillator cycle. So a half-period of the main output is always one whole oscillator cycle, and the very first half-period after a start uses the longer initial segment.

The block runs free while either of its two gate inputs is active. Without a gate it acts as a one-shot. A pulse is started by a rising edge of the positive trigger while the negative trigger is low, or by a falling edge of the negative trigger while the positive trigger is high. A retrigger input also starts a pulse. While that input stays high, or after a new rising edge on it, the pulse is extended by whole oscillator cycles. A stop input ends any activity at once and holds the outputs idle. Every control input is asynchronous and passes through a synchronizer before use.

Top module: `gated_pulse_timer`

## Requirements
- R1: The oscillator starts when `run_hi` is 1 or `run_lo_n` is 0. Any change on a control input reaches `q` and `osc` on the third rising clock edge after it is applied.
- R2: While free running, the first high half of `q` lasts `len_init + len_lo` cycles. Every later half of `q`, high or low, lasts `len_hi + len_lo` cycles.
- R3: `osc` is high for the high segment and low for the low segment of each oscillator cycle. The first cycle's high segment lasts `len_init` and later ones last `len_hi`.
- R4: When both gates go inactive, a free-running `q` and `osc` drop to 0 under the R1 latency and stay at 0.
- R5: A rising edge of `trig_p` while `trig_n` is 0 gives one `q` pulse of exactly `len_init + len_lo` cycles. A rising edge of `trig_p` while `trig_n` is 1 has no effect.
- R6: A falling edge of `trig_n` while `trig_p` is 1 gives the same pulse. A falling edge of `trig_n` while `trig_p` is 0 has no effect.
- R7: Trigger edges that arrive during a one-shot pulse are ignored. The pulse width does not change and no second pulse follows.
- R8: A rising edge of `retrig` starts a pulse. At the end of each oscillator cycle the pulse goes on for another `len_hi + len_lo` cycles if `retrig` is still high or has risen again since the last cycle end. Two short pulses on `retrig` therefore give a width of `len_init + len_hi + 2*len_lo`.
- R9: A high `stop` forces `q` to 0 under the R1 latency. While `stop` is high, triggers and gates start nothing.
- R10: While `rst_n` is low, `q` is 0, `q_n` is 1 and `osc` is 0 at once, without a clock edge.
- R11: A length input of 0 acts as a length of 1.
- R12: `q_n` is always the complement of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_hi | input | 1 | Oscillator gate, active high |
| run_lo_n | input | 1 | Oscillator gate, active low |
| trig_p | input | 1 | Rising-edge trigger |
| trig_n | input | 1 | Falling-edge trigger |
| retrig | input | 1 | Retriggering start and extend input |
| stop | input | 1 | Forces the outputs idle while high |
| len_init | input | CNT_W | Initial high segment in cycles |
| len_hi | input | CNT_W | Regular high segment in cycles |
| len_lo | input | CNT_W | Low segment in cycles |
| q | output | 1 | Divided main output |
| q_n | output | 1 | Complement of `q` |
| osc | output | 1 | Oscillator output |

## Verification
Every control input passes through two synchronizer flops, and the control registers add one more. So `q` and `osc` change on the third rising edge after the bench changes an input. The bench changes inputs on falling edges and samples the outputs on falling edges. It expects the first change at the third sample and checks the sample just before as well, so both the latency and the starting point of each width are pinned down. Widths are counted as the number of falling-edge samples in which an output holds a value. For the retrigger tests, all samples taken inside a fixed window are counted. An extra pulse or a missed extension therefore shows up as a wrong total.

// File: rtl/ptimer_pkg.sv
`timescale 1ns/1ps
package ptimer_pkg;
  typedef enum logic {SEG_LO = 1'b0, SEG_HI = 1'b1} seg_e;

  localparam int IN_COUNT     = 6;
  localparam int IDX_RUN_HI   = 0;
  localparam int IDX_RUN_LO_N = 1;
  localparam int IDX_TRIG_P   = 2;
  localparam int IDX_TRIG_N   = 3;
  localparam int IDX_RETRIG   = 4;
  localparam int IDX_STOP     = 5;
endpackage

// File: rtl/ptimer_sync.sv
`timescale 1ns/1ps
module ptimer_sync #(
  parameter int              W       = 6,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/ptimer_edge.sv
`timescale 1ns/1ps
module ptimer_edge #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] tog
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign tog = lvl ^ prev_q;
endmodule

// File: rtl/ptimer_phase.sv
`timescale 1ns/1ps
module ptimer_phase
  import ptimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             next_i,
  input  logic             kill_i,
  input  logic [CNT_W-1:0] len_init_i,
  input  logic [CNT_W-1:0] len_hi_i,
  input  logic [CNT_W-1:0] len_lo_i,
  output logic             busy_o,
  output logic             osc_o,
  output logic             cyc_end_o
);
  logic             active_q, active_d;
  seg_e             seg_q, seg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Load value for a segment; a zero length behaves as one (R11)
  function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  assign cyc_end_o = active_q && (seg_q == SEG_LO) && (cnt_q == '0);
  assign busy_o    = active_q;
  assign osc_o     = active_q && (seg_q == SEG_HI);

  always_comb begin
    active_d = active_q;
    seg_d    = seg_q;
    cnt_d    = cnt_q;
    if (kill_i) begin
      active_d = 1'b0;
      seg_d    = SEG_LO;
      cnt_d    = '0;
    end else if (start_i) begin
      active_d = 1'b1;
      seg_d    = SEG_HI;
      cnt_d    = load_of(len_init_i);
    end else if (active_q) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (seg_q == SEG_HI) begin
        seg_d = SEG_LO;
        cnt_d = load_of(len_lo_i);
      end else if (next_i) begin
        seg_d = SEG_HI;
        cnt_d = load_of(len_hi_i);
      end else begin
        active_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      seg_q    <= SEG_LO;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      seg_q    <= seg_d;
      cnt_q    <= cnt_d;
    end
  end

  assert_first_seg_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !kill_i) |=> (busy_o && osc_o));

  assert_cycle_end_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end_o && !next_i && !start_i) |=> !busy_o);
endmodule

// File: rtl/ptimer_ctrl.sv
`timescale 1ns/1ps
module ptimer_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic stop_i,
  input  logic trig_go_i,
  input  logic rtr_lvl_i,
  input  logic rtr_rise_i,
  input  logic busy_i,
  input  logic cyc_end_i,
  output logic start_o,
  output logic next_o,
  output logic kill_o,
  output logic q_o
);
  logic q_q, q_d;
  logic free_q, free_d;
  logic ext_q, ext_d;
  logic cont;

  assign kill_o  = stop_i || (busy_i && free_q && !en_i);
  assign start_o = !stop_i && !busy_i && (en_i || trig_go_i || rtr_rise_i);
  assign cont    = ext_q || rtr_lvl_i;
  assign next_o  = busy_i && cyc_end_i && (free_q || cont);
  assign q_o     = q_q;

  always_comb begin
    q_d    = q_q;
    free_d = free_q;
    ext_d  = ext_q;
    if (kill_o) begin
      q_d    = 1'b0;
      free_d = 1'b0;
      ext_d  = 1'b0;
    end else if (start_o) begin
      q_d    = 1'b1;
      free_d = en_i;
      ext_d  = 1'b0;
    end else if (busy_i) begin
      if (cyc_end_i) begin
        ext_d = 1'b0;
        if (free_q)     q_d = !q_q;
        else if (!cont) q_d = 1'b0;
      end else if (!free_q && rtr_rise_i) begin
        ext_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= 1'b0;
      free_q <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      q_q    <= q_d;
      free_q <= free_d;
      ext_q  <= ext_d;
    end
  end

  assert_stop_forces_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !q_q);

  assert_q_steady_in_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !cyc_end_i && !kill_o) |=> $stable(q_q));

  assert_idle_stays_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !start_o) |=> !q_q);
endmodule

// File: rtl/gated_pulse_timer.sv
`timescale 1ns/1ps
module gated_pulse_timer
  import ptimer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_hi,
  input  logic             run_lo_n,
  input  logic             trig_p,
  input  logic             trig_n,
  input  logic             retrig,
  input  logic             stop,
  input  logic [CNT_W-1:0] len_init,
  input  logic [CNT_W-1:0] len_hi,
  input  logic [CNT_W-1:0] len_lo,
  output logic             q,
  output logic             q_n,
  output logic             osc
);
  localparam logic [IN_COUNT-1:0] SYNC_RST = IN_COUNT'(1) << IDX_RUN_LO_N;
  localparam int                  EDGE_W   = IDX_RETRIG - IDX_TRIG_P + 1;

  logic [IN_COUNT-1:0] raw, lvl;
  logic [EDGE_W-1:0]   tog;
  logic en, trig_go, rtr_rise;
  logic start, next, kill, busy, cyc_end;

  assign raw = {stop, retrig, trig_n, trig_p, run_lo_n, run_hi};

  ptimer_sync #(.W(IN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(raw), .dout(lvl));

  ptimer_edge #(.W(EDGE_W), .RST_VAL(SYNC_RST[IDX_RETRIG:IDX_TRIG_P])) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(lvl[IDX_RETRIG:IDX_TRIG_P]), .tog(tog));

  assign en       = lvl[IDX_RUN_HI] || !lvl[IDX_RUN_LO_N];
  assign trig_go  = (tog[IDX_TRIG_P-IDX_TRIG_P] && lvl[IDX_TRIG_P] && !lvl[IDX_TRIG_N])
                 || (tog[IDX_TRIG_N-IDX_TRIG_P] && !lvl[IDX_TRIG_N] && lvl[IDX_TRIG_P]);
  assign rtr_rise = tog[IDX_RETRIG-IDX_TRIG_P] && lvl[IDX_RETRIG];

  ptimer_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .stop_i(lvl[IDX_STOP]),
    .trig_go_i(trig_go), .rtr_lvl_i(lvl[IDX_RETRIG]), .rtr_rise_i(rtr_rise),
    .busy_i(busy), .cyc_end_i(cyc_end),
    .start_o(start), .next_o(next), .kill_o(kill), .q_o(q));

  ptimer_phase #(.CNT_W(CNT_W)) phase_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .next_i(next), .kill_i(kill),
    .len_init_i(len_init), .len_hi_i(len_hi), .len_lo_i(len_lo),
    .busy_o(busy), .osc_o(osc), .cyc_end_o(cyc_end));

  assign q_n = !q;
endmodule

// File: tb/gated_pulse_timer_tb_top.sv
`timescale 1ns/1ps
module gated_pulse_timer_tb_top;
  localparam int CW       = 16;
  localparam int WD_LIMIT = 100000;

  typedef struct packed {
    logic [1:0]    kind;   // 0 positive trigger, 1 negative trigger, 2 retrigger
    logic [CW-1:0] ti;
    logic [CW-1:0] th;
    logic [CW-1:0] tl;
    logic [CW-1:0] width;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 16'd3,  16'd2, 16'd2, 16'd5},
    '{2'd0, 16'd1,  16'd1, 16'd1, 16'd2},
    '{2'd1, 16'd6,  16'd4, 16'd3, 16'd9},
    '{2'd2, 16'd4,  16'd3, 16'd2, 16'd6},
    '{2'd0, 16'd0,  16'd0, 16'd0, 16'd2},
    '{2'd1, 16'd10, 16'd1, 16'd7, 16'd17}
  };

  logic clk = 1'b0;
  logic rst_n, run_hi, run_lo_n, trig_p, trig_n, retrig, stop;
  logic [CW-1:0] len_init, len_hi, len_lo;
  logic q, q_n, osc;
  int checks = 0;
  int fails  = 0;

  always #5 clk = !clk;

  gated_pulse_timer #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_hi(run_hi), .run_lo_n(run_lo_n),
    .trig_p(trig_p), .trig_n(trig_n), .retrig(retrig), .stop(stop),
    .len_init(len_init), .len_hi(len_hi), .len_lo(len_lo),
    .q(q), .q_n(q_n), .osc(osc));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_of(input bit sel, input bit val, output int n);
    n = 0;
    while (((sel ? osc : q) == val) && n < 5000) begin
      tick(1);
      n++;
    end
  endtask

  task automatic set_len(input int a, input int b, input int c);
    len_init = CW'(a); len_hi = CW'(b); len_lo = CW'(c);
  endtask

  initial begin
    tick(WD_LIMIT);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat, w, n;
    string tag;
    rst_n = 1'b0; run_hi = 1'b0; run_lo_n = 1'b1; trig_p = 1'b0; trig_n = 1'b0;
    retrig = 1'b0; stop = 1'b0;
    set_len(1, 1, 1);
    tick(1);
    // R10: outputs idle during reset
    chk(q == 1'b0 && q_n == 1'b1 && osc == 1'b0, "R10 reset state", {q, q_n, osc}, 3'b010);
    tick(2);
    rst_n = 1'b1;
    tick(5);
    chk(q == 1'b0, "R10 idle after reset release", q, 0);

    // Vector table: one-shot widths and start latency
    for (int i = 0; i < NVEC; i++) begin
      set_len(int'(VEC[i].ti), int'(VEC[i].th), int'(VEC[i].tl));
      tag = (VEC[i].ti == 0) ? "R11" : (VEC[i].kind == 2'd0) ? "R5" :
            (VEC[i].kind == 2'd1) ? "R6" : "R8";
      if (VEC[i].kind == 2'd1) begin
        trig_n = 1'b1; tick(5);
        trig_p = 1'b1; tick(5);
        chk(q == 1'b0, "R5 positive edge with trig_n high ignored", q, 0);
      end
      case (VEC[i].kind)
        2'd0:    trig_p = 1'b1;
        2'd1:    trig_n = 1'b0;
        default: retrig = 1'b1;
      endcase
      lat = 0;
      do begin
        tick(1);
        lat++;
        if (lat == 1) begin
          if (VEC[i].kind == 2'd0) trig_p = 1'b0;
          if (VEC[i].kind == 2'd1) trig_n = 1'b1;
          retrig = 1'b0;
        end
      end while (!q && lat < 20);
      chk(lat == 3, {tag, " start latency (R1)"}, lat, 3);
      chk(q_n == !q, "R12 complement while high", q_n, !q);
      run_of(1'b0, 1'b1, w);
      chk(w == int'(VEC[i].width), {tag, " pulse width"}, w, int'(VEC[i].width));
      chk(q_n == 1'b1, "R12 complement after pulse", q_n, 1);
      if (VEC[i].kind == 2'd1) begin
        trig_p = 1'b0; tick(5);
        trig_n = 1'b0; tick(5);
        chk(q == 1'b0, "R6 negative edge with trig_p low ignored", q, 0);
      end
      tick(3);
    end

    // R2, R3: oscillator segments in free-running mode
    set_len(5, 3, 2);
    run_hi = 1'b1;
    lat = 0;
    do begin tick(1); lat++; end while (!q && lat < 20);
    chk(lat == 3, "R1 gate latency", lat, 3);
    run_of(1'b1, 1'b1, n); chk(n == 5, "R3 first osc high", n, 5);
    run_of(1'b1, 1'b0, n); chk(n == 2, "R3 osc low", n, 2);
    run_of(1'b1, 1'b1, n); chk(n == 3, "R3 later osc high", n, 3);
    run_of(1'b1, 1'b0, n); chk(n == 2, "R3 later osc low", n, 2);
    run_hi = 1'b0;
    tick(8);
    chk(q == 1'b0 && osc == 1'b0, "R4 stop after run_hi drop", {q, osc}, 0);

    // R1, R2, R4: Q halves with the active-low gate
    run_lo_n = 1'b0;
    lat = 0;
    do begin tick(1); lat++; end while (!q && lat < 20);
    chk(lat == 3, "R1 active-low gate latency", lat, 3);
    run_of(1'b0, 1'b1, n); chk(n == 7, "R2 first Q high half", n, 7);
    run_of(1'b0, 1'b0, n); chk(n == 5, "R2 Q low half", n, 5);
    run_lo_n = 1'b1;
    tick(2);
    chk(q == 1'b1, "R4 Q still high before latency", q, 1);
    tick(1);
    chk(q == 1'b0, "R4 Q low on third edge", q, 0);
    n = 0;
    for (int t = 0; t < 12; t++) begin tick(1); if (q || osc) n++; end
    chk(n == 0, "R4 stays idle", n, 0);

    // R7: trigger during a one-shot ignored
    set_len(10, 1, 5);
    trig_p = 1'b1; tick(1); trig_p = 1'b0;
    w = 0;
    for (int t = 2; t <= 45; t++) begin
      tick(1);
      if (t == 6) trig_p = 1'b1;
      if (t == 7) trig_p = 1'b0;
      if (q) w++;
    end
    chk(w == 15, "R7 width with ignored trigger", w, 15);

    // R8: retrigger held high for 30 cycles
    set_len(4, 3, 2);
    retrig = 1'b1;
    w = 0;
    for (int t = 1; t <= 70; t++) begin
      tick(1);
      if (t == 30) retrig = 1'b0;
      if (q) w++;
    end
    chk(w == 31, "R8 held retrigger width", w, 31);

    // R8: two short retrigger pulses
    retrig = 1'b1;
    w = 0;
    for (int t = 1; t <= 40; t++) begin
      tick(1);
      if (t == 1) retrig = 1'b0;
      if (t == 3) retrig = 1'b1;
      if (t == 4) retrig = 1'b0;
      if (q) w++;
    end
    chk(w == 11, "R8 two-pulse width", w, 11);

    // R9: stop ends a pulse and blocks starts
    set_len(20, 1, 5);
    trig_p = 1'b1; tick(1); trig_p = 1'b0; tick(2);
    chk(q == 1'b1, "R9 pulse running", q, 1);
    tick(3);
    stop = 1'b1;
    tick(2);
    chk(q == 1'b1, "R9 before stop latency", q, 1);
    tick(1);
    chk(q == 1'b0, "R9 stop ends pulse", q, 0);
    trig_p = 1'b1; tick(1); trig_p = 1'b0; run_hi = 1'b1;
    tick(10);
    chk(q == 1'b0 && osc == 1'b0, "R9 starts blocked", {q, osc}, 0);
    run_hi = 1'b0; tick(4);
    stop = 1'b0;
    tick(10);
    chk(q == 1'b0, "R9 nothing pending after release", q, 0);

    // R10: asynchronous reset mid-run
    run_hi = 1'b1;
    tick(6);
    rst_n = 1'b0;
    #1;
    chk(q == 1'b0 && q_n == 1'b1 && osc == 1'b0, "R10 async reset", {q, q_n, osc}, 3'b010);
    run_hi = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(5);
    chk(q == 1'b0, "R10 idle after second reset", q, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule